// File: doc/BRIEF.md
# Outstanding Miss Tracker

This block keeps the book of cache misses that are still in flight in a non-blocking cache. Each miss presents a block address and the tag of the instruction that wants the data. The address is compared with every entry that is waiting on memory. A new address takes a free entry, records the instruction and sends one request to memory. An address that is already outstanding is a half-miss: the instruction joins that entry's wait list and memory is not asked again.

When a refill for a waiting block comes back, the entry starts draining. Its waiting instructions are woken one per cycle, in the order they joined. The entry is released in the cycle that its last wake-up is issued. The data itself is not stored or forwarded. The requester is stalled through a ready signal whenever its miss cannot be taken in the current cycle.

Top module: `mshr_file`

## Requirements
- R1: After reset every entry is free: `miss_ready` is 1, and `mem_req_valid`, `wake_valid` and `fill_err` are 0.
- R2: A miss accepted (`miss_valid` and `miss_ready` high at a clock edge) whose address matches no waiting entry takes the lowest-numbered free entry. In the next cycle `mem_req_valid` is high for one cycle, with `mem_req_addr` equal to the miss address.
- R3: An accepted miss whose address matches a waiting entry is appended to that entry's wait list and produces no memory request.
- R4: A refill that matches a waiting entry makes it drain. Starting one cycle after the refill edge, when the drain logic is idle, `wake_valid` is high for one cycle per waiting instruction. `wake_tag` gives the tags in the order the misses were accepted.
- R5: An entry is free again from the edge after its last wake-up. A later miss to the same address allocates a fresh entry and issues a new memory request.
- R6: When no entry is free, a miss to an address with no matching entry sees `miss_ready` low. A half-miss to a waiting entry with room still sees `miss_ready` high.
- R7: When the matching entry already holds `WAITERS` instructions, `miss_ready` is low.
- R8: `miss_ready` is low when the miss address matches an entry that is draining, or equals `fill_addr` while `fill_valid` is high. In the second case the refill is still taken.
- R9: A refill whose address matches no waiting entry is ignored: it issues no wake-up and changes no entry. `fill_err` is high for one cycle in the next cycle.
- R10: Wake-ups of two entries never interleave. A refill that arrives while another entry drains is served after that entry's last wake-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | A miss is presented |
| miss_addr | input | ADDR_W | Block address of the miss |
| miss_tag | input | TAG_W | Tag of the requesting instruction |
| miss_ready | output | 1 | The miss is taken at this edge |
| fill_valid | input | 1 | Refill data has returned |
| fill_addr | input | ADDR_W | Block address of the refill |
| mem_req_valid | output | 1 | One-cycle request to memory |
| mem_req_addr | output | ADDR_W | Block address to fetch |
| wake_valid | output | 1 | One instruction is woken |
| wake_tag | output | TAG_W | Tag of the woken instruction |
| fill_err | output | 1 | One-cycle flag for an unmatched refill |

## Verification
Corrupt entry state shows up at the ports within a few cycles. A lost or duplicated address match turns a half-miss into a second memory request, or a new miss into a silent append, in the cycle after the miss. A wrong waiter count or read pointer gives a missing, extra or reordered wake tag, or ends the drain on the wrong cycle. A release that comes too early or too late changes `miss_ready`, or makes a later miss to the same address miss its fresh request. The bench predicts every request, wake-up and error flag with its exact cycle. It also predicts `miss_ready` on every attempt, so any of these faults is caught on the cycle it first shows.

// File: rtl/mshr_pkg.sv
package mshr_pkg;
  // lifecycle of one tracking entry
  typedef enum logic [1:0] {
    ENT_FREE  = 2'd0,
    ENT_WAIT  = 2'd1,
    ENT_DRAIN = 2'd2
  } ent_state_e;
endpackage

// File: rtl/mshr_prienc.sv
module mshr_prienc #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec,
  output logic          any,
  output logic [IW-1:0] idx
);
  // lowest set bit wins
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end

  assign any = |vec;
endmodule

// File: rtl/mshr_lookup.sv
module mshr_lookup #(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 26,
  localparam int EI_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [ENTRIES-1:0]        wait_v,
  input  logic [ENTRIES-1:0]        drain_v,
  input  logic [ENTRIES*ADDR_W-1:0] addr_flat,
  input  logic [ADDR_W-1:0]         miss_addr,
  input  logic [ADDR_W-1:0]         fill_addr,
  output logic                      miss_hit_w,
  output logic                      miss_hit_d,
  output logic [EI_W-1:0]           miss_idx,
  output logic                      fill_hit,
  output logic [EI_W-1:0]           fill_idx,
  output logic                      free_any,
  output logic [EI_W-1:0]           free_idx,
  output logic                      drain_any,
  output logic [EI_W-1:0]           drain_idx
);
  logic [ENTRIES-1:0] mhit_w, mhit_d, fhit, free_v;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    logic [ADDR_W-1:0] ent_a;
    assign ent_a     = addr_flat[g*ADDR_W +: ADDR_W];
    assign mhit_w[g] = wait_v[g]  && (ent_a == miss_addr);
    assign mhit_d[g] = drain_v[g] && (ent_a == miss_addr);
    assign fhit[g]   = wait_v[g]  && (ent_a == fill_addr);
    assign free_v[g] = !wait_v[g] && !drain_v[g];
  end

  assign miss_hit_d = |mhit_d;

  mshr_prienc #(.N(ENTRIES)) u_miss  (.vec(mhit_w),  .any(miss_hit_w), .idx(miss_idx));
  mshr_prienc #(.N(ENTRIES)) u_fill  (.vec(fhit),    .any(fill_hit),   .idx(fill_idx));
  mshr_prienc #(.N(ENTRIES)) u_free  (.vec(free_v),  .any(free_any),   .idx(free_idx));
  mshr_prienc #(.N(ENTRIES)) u_drain (.vec(drain_v), .any(drain_any),  .idx(drain_idx));

  // R3: one block address is never held by two waiting entries
  p_single_match_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(mhit_w));
  // R8: a block is never waiting and draining in two entries at once
  p_no_split_block_r8: assert property (@(posedge clk) disable iff (rst)
    !((|mhit_w) && (|mhit_d)));
endmodule

// File: rtl/mshr_waitlist.sv
module mshr_waitlist #(
  parameter int ENTRIES = 4,
  parameter int WAITERS = 4,
  parameter int TAG_W   = 6,
  localparam int EI_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int WP_W   = (WAITERS > 1) ? $clog2(WAITERS) : 1,
  localparam int DEPTH  = ENTRIES * WAITERS,
  localparam int MA_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [EI_W-1:0]  widx,
  input  logic [WP_W-1:0]  wslot,
  input  logic [TAG_W-1:0] wtag,
  input  logic [EI_W-1:0]  ridx,
  input  logic [WP_W-1:0]  rslot,
  output logic [TAG_W-1:0] rtag
);
  // one write port, one read port: fits distributed RAM
  logic [TAG_W-1:0] mem [DEPTH];
  logic [MA_W-1:0]  waddr, raddr;

  assign waddr = MA_W'(widx) * MA_W'(WAITERS) + MA_W'(wslot);
  assign raddr = MA_W'(ridx) * MA_W'(WAITERS) + MA_W'(rslot);

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wtag;
  end

  assign rtag = mem[raddr];
endmodule

// File: rtl/mshr_file.sv
module mshr_file
  import mshr_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int WAITERS = 4,
  parameter int ADDR_W  = 26,
  parameter int TAG_W   = 6,
  localparam int EI_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int WP_W   = (WAITERS > 1) ? $clog2(WAITERS) : 1,
  localparam int WC_W   = $clog2(WAITERS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              miss_valid,
  input  logic [ADDR_W-1:0] miss_addr,
  input  logic [TAG_W-1:0]  miss_tag,
  output logic              miss_ready,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic              wake_valid,
  output logic [TAG_W-1:0]  wake_tag,
  output logic              fill_err
);
  ent_state_e        ent_st   [ENTRIES];
  logic [ADDR_W-1:0] ent_addr [ENTRIES];
  logic [WC_W-1:0]   ent_cnt  [ENTRIES];
  logic [WP_W-1:0]   ent_rd   [ENTRIES];

  logic [ENTRIES-1:0]        wait_v, drain_v;
  logic [ENTRIES*ADDR_W-1:0] addr_flat;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_flat
    assign wait_v[g]  = (ent_st[g] == ENT_WAIT);
    assign drain_v[g] = (ent_st[g] == ENT_DRAIN);
    assign addr_flat[g*ADDR_W +: ADDR_W] = ent_addr[g];
  end

  logic            miss_hit_w, miss_hit_d, fill_hit, free_any, drain_any;
  logic [EI_W-1:0] miss_idx, fill_idx, free_idx, drain_idx;

  mshr_lookup #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_lookup (
    .clk(clk), .rst(rst),
    .wait_v(wait_v), .drain_v(drain_v), .addr_flat(addr_flat),
    .miss_addr(miss_addr), .fill_addr(fill_addr),
    .miss_hit_w(miss_hit_w), .miss_hit_d(miss_hit_d), .miss_idx(miss_idx),
    .fill_hit(fill_hit), .fill_idx(fill_idx),
    .free_any(free_any), .free_idx(free_idx),
    .drain_any(drain_any), .drain_idx(drain_idx)
  );

  // admission
  logic same_fill, room, accept, alloc, append, fill_ok;
  assign same_fill  = fill_valid && (fill_addr == miss_addr);
  assign room       = ent_cnt[miss_idx] < WC_W'(WAITERS);
  assign miss_ready = !same_fill && (miss_hit_w ? room : (!miss_hit_d && free_any));
  assign accept     = miss_valid && miss_ready;
  assign alloc      = accept && !miss_hit_w;
  assign append     = accept && miss_hit_w;
  assign fill_ok    = fill_valid && fill_hit;

  // drain engine: sticks to one entry until its list is empty
  logic            act;
  logic [EI_W-1:0] cur, sel;
  logic            emit, last;
  logic [TAG_W-1:0] rtag;

  assign sel  = act ? cur : drain_idx;
  assign emit = act || drain_any;
  assign last = (WC_W'(ent_rd[sel]) + WC_W'(1)) == ent_cnt[sel];

  mshr_waitlist #(.ENTRIES(ENTRIES), .WAITERS(WAITERS), .TAG_W(TAG_W)) u_wl (
    .clk(clk),
    .we(accept),
    .widx(alloc ? free_idx : miss_idx),
    .wslot(alloc ? WP_W'(0) : WP_W'(ent_cnt[miss_idx])),
    .wtag(miss_tag),
    .ridx(sel),
    .rslot(ent_rd[sel]),
    .rtag(rtag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) begin
        ent_st[i]   <= ENT_FREE;
        ent_addr[i] <= '0;
        ent_cnt[i]  <= '0;
        ent_rd[i]   <= '0;
      end
      act           <= 1'b0;
      cur           <= '0;
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
      wake_valid    <= 1'b0;
      wake_tag      <= '0;
      fill_err      <= 1'b0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (alloc && free_idx == EI_W'(i)) begin
          ent_st[i]   <= ENT_WAIT;
          ent_addr[i] <= miss_addr;
          ent_cnt[i]  <= WC_W'(1);
          ent_rd[i]   <= '0;
        end
        if (append && miss_idx == EI_W'(i)) ent_cnt[i] <= ent_cnt[i] + WC_W'(1);
        if (fill_ok && fill_idx == EI_W'(i)) ent_st[i] <= ENT_DRAIN;
        if (emit && sel == EI_W'(i)) begin
          ent_rd[i] <= ent_rd[i] + WP_W'(1);
          if (last) ent_st[i] <= ENT_FREE;
        end
      end
      if (emit) begin
        act <= !last;
        cur <= sel;
      end
      mem_req_valid <= alloc;
      mem_req_addr  <= miss_addr;
      wake_valid    <= emit;
      wake_tag      <= rtag;
      fill_err      <= fill_valid && !fill_hit;
    end
  end

  // R2: a memory request only follows an accepted miss
  p_req_after_accept_r2: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> $past(miss_valid && miss_ready));
  // R9: the error flag only follows a refill
  p_err_after_fill_r9: assert property (@(posedge clk) disable iff (rst)
    fill_err |-> $past(fill_valid));
  // R6: with every entry busy a new block is refused
  p_full_stall_r6: assert property (@(posedge clk) disable iff (rst)
    (!free_any && !miss_hit_w) |-> !miss_ready);
  // R10: the engine keeps its entry while it is busy
  p_sticky_drain_r10: assert property (@(posedge clk) disable iff (rst)
    ($past(act) && act) |-> $stable(cur));
  // R7: a wait list never grows past its capacity
  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      p_no_overflow_r7: assert (rst || ent_cnt[i] <= WC_W'(WAITERS));
    end
  end
endmodule

// File: tb/sim_mshr_file.sv
module sim_mshr_file;
  localparam int NE = 4;
  localparam int NW = 4;
  localparam int AW = 26;
  localparam int TW = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          miss_valid = 1'b0;
  logic [AW-1:0] miss_addr  = '0;
  logic [TW-1:0] miss_tag   = '0;
  logic          miss_ready;
  logic          fill_valid = 1'b0;
  logic [AW-1:0] fill_addr  = '0;
  logic          mem_req_valid;
  logic [AW-1:0] mem_req_addr;
  logic          wake_valid;
  logic [TW-1:0] wake_tag;
  logic          fill_err;

  mshr_file #(.ENTRIES(NE), .WAITERS(NW), .ADDR_W(AW), .TAG_W(TW)) u0 (
    .clk(clk), .rst(rst),
    .miss_valid(miss_valid), .miss_addr(miss_addr), .miss_tag(miss_tag),
    .miss_ready(miss_ready),
    .fill_valid(fill_valid), .fill_addr(fill_addr),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .wake_valid(wake_valid), .wake_tag(wake_tag), .fill_err(fill_err)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0;
  int bad   = 0;
  bit mon_on = 1'b0;

  typedef struct { int cyc; logic [31:0] val; } item_t;
  item_t q_mem[$];
  item_t q_wake[$];
  item_t q_err[$];

  // reference model: 0 free, 1 waiting, 2 draining
  int          m_st   [NE];
  logic [AW-1:0] m_addr [NE];
  int          m_n    [NE];
  logic [TW-1:0] m_tag [NE][NW];
  int          m_free_at [NE];
  int          eng_free = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic void refresh(int e);
    for (int i = 0; i < NE; i++)
      if (m_st[i] == 2 && e >= m_free_at[i]) m_st[i] = 0;
  endfunction

  function automatic int find(logic [AW-1:0] a);
    for (int i = 0; i < NE; i++)
      if (m_st[i] != 0 && m_addr[i] == a) return i;
    return -1;
  endfunction

  function automatic void model_fill(logic [AW-1:0] a, int e);
    int k;
    int st;
    item_t it;
    k = find(a);
    if (k >= 0 && m_st[k] == 1) begin
      st = (e + 1 > eng_free) ? e + 1 : eng_free;
      for (int j = 0; j < m_n[k]; j++) begin
        it.cyc = st + j; it.val = 32'(m_tag[k][j]);
        q_wake.push_back(it);
      end
      m_free_at[k] = st + m_n[k];
      eng_free     = st + m_n[k];
      m_st[k]      = 2;
    end else begin
      it.cyc = e; it.val = 32'd1;
      q_err.push_back(it);
    end
  endfunction

  task automatic do_miss(input logic [AW-1:0] a, input logic [TW-1:0] t, input string req);
    int e, k, f;
    bit rdy;
    item_t it;
    @(negedge clk);
    e = cyc + 1;
    refresh(e);
    k = find(a);
    f = -1;
    for (int i = NE - 1; i >= 0; i--) if (m_st[i] == 0) f = i;
    if (k >= 0) rdy = (m_st[k] == 1) && (m_n[k] < NW);
    else        rdy = (f >= 0);
    miss_valid = 1'b1; miss_addr = a; miss_tag = t;
    #1;
    chk(miss_ready == rdy, req, "miss_ready", 32'(miss_ready), 32'(rdy));
    @(posedge clk);
    #1;
    miss_valid = 1'b0;
    if (rdy) begin
      if (k >= 0) begin
        m_tag[k][m_n[k]] = t;
        m_n[k]++;
      end else begin
        m_st[f] = 1; m_addr[f] = a; m_n[f] = 1; m_tag[f][0] = t;
        it.cyc = e; it.val = 32'(a);
        q_mem.push_back(it);
      end
    end
  endtask

  task automatic do_fill(input logic [AW-1:0] a);
    int e;
    @(negedge clk);
    e = cyc + 1;
    refresh(e);
    fill_valid = 1'b1; fill_addr = a;
    model_fill(a, e);
    @(posedge clk);
    #1;
    fill_valid = 1'b0;
  endtask

  // R8: miss and refill to one block in the same cycle
  task automatic do_fill_miss(input logic [AW-1:0] a, input logic [TW-1:0] t);
    int e;
    @(negedge clk);
    e = cyc + 1;
    refresh(e);
    fill_valid = 1'b1; fill_addr = a;
    miss_valid = 1'b1; miss_addr = a; miss_tag = t;
    #1;
    chk(miss_ready == 1'b0, "R8", "miss_ready same-cycle fill", 32'(miss_ready), 32'd0);
    model_fill(a, e);
    @(posedge clk);
    #1;
    fill_valid = 1'b0; miss_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (mon_on) begin
      while (q_mem.size() > 0 && q_mem[0].cyc < cyc) begin
        chk(1'b0, "R2", "missing mem_req", 32'd0, q_mem[0].val);
        void'(q_mem.pop_front());
      end
      if (mem_req_valid) begin
        if (q_mem.size() > 0 && q_mem[0].cyc == cyc) begin
          chk(mem_req_addr == q_mem[0].val[AW-1:0], "R2", "mem_req_addr",
              32'(mem_req_addr), q_mem[0].val);
          void'(q_mem.pop_front());
        end else chk(1'b0, "R3", "unexpected mem_req", 32'(mem_req_addr), 32'd0);
      end
      while (q_wake.size() > 0 && q_wake[0].cyc < cyc) begin
        chk(1'b0, "R4", "missing wake", 32'd0, q_wake[0].val);
        void'(q_wake.pop_front());
      end
      if (wake_valid) begin
        if (q_wake.size() > 0 && q_wake[0].cyc == cyc) begin
          chk(wake_tag == q_wake[0].val[TW-1:0], "R4", "wake_tag",
              32'(wake_tag), q_wake[0].val);
          void'(q_wake.pop_front());
        end else chk(1'b0, "R10", "unexpected wake", 32'(wake_tag), 32'd0);
      end
      while (q_err.size() > 0 && q_err[0].cyc < cyc) begin
        chk(1'b0, "R9", "missing fill_err", 32'd0, 32'd1);
        void'(q_err.pop_front());
      end
      if (fill_err) begin
        if (q_err.size() > 0 && q_err[0].cyc == cyc) begin
          chk(1'b1, "R9", "fill_err", 32'd1, 32'd1);
          void'(q_err.pop_front());
        end else chk(1'b0, "R9", "unexpected fill_err", 32'd1, 32'd0);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog", "run did not end", 32'(cyc), 32'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  localparam logic [AW-1:0] A = 26'h100, B = 26'h200, C = 26'h300,
                            D = 26'h400, E = 26'h500, F = 26'h600;

  initial begin
    for (int i = 0; i < NE; i++) begin m_st[i] = 0; m_n[i] = 0; m_free_at[i] = 0; end
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1: idle state after reset
    chk(miss_ready == 1'b1, "R1", "miss_ready", 32'(miss_ready), 32'd1);
    chk(mem_req_valid == 1'b0, "R1", "mem_req_valid", 32'(mem_req_valid), 32'd0);
    chk(wake_valid == 1'b0, "R1", "wake_valid", 32'(wake_valid), 32'd0);
    chk(fill_err == 1'b0, "R1", "fill_err", 32'(fill_err), 32'd0);
    mon_on = 1'b1;

    do_miss(A, 6'd1, "R2");
    do_miss(A, 6'd2, "R3");
    do_miss(A, 6'd3, "R3");
    do_fill(A);                // R4: tags 1,2,3 in order
    idle(6);
    do_miss(A, 6'd4, "R5");    // R5: fresh request after release
    do_fill(A);
    idle(4);

    do_fill(E);                // R9: nothing waits on E

    do_miss(B, 6'd5, "R2");
    do_miss(C, 6'd6, "R2");
    do_miss(D, 6'd7, "R2");
    do_miss(E, 6'd8, "R2");
    do_miss(F, 6'd9, "R6");    // R6: all entries busy
    do_miss(B, 6'd10, "R6");   // R6: half-miss still taken
    do_miss(B, 6'd11, "R3");
    do_miss(B, 6'd12, "R3");
    do_miss(B, 6'd13, "R7");   // R7: list of B is full

    do_fill(C);
    do_miss(C, 6'd14, "R8");   // R8: C is draining
    do_fill_miss(D, 6'd15);
    idle(4);

    do_fill(B);                // R10: B drains four tags
    do_fill(E);                // R10: E waits behind B
    idle(10);
    do_miss(F, 6'd16, "R5");
    do_fill(F);
    idle(6);

    chk(q_mem.size() == 0, "R2", "pending mem_req", 32'(q_mem.size()), 32'd0);
    chk(q_wake.size() == 0, "R4", "pending wake", 32'(q_wake.size()), 32'd0);
    chk(q_err.size() == 0, "R9", "pending fill_err", 32'(q_err.size()), 32'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule